// File: doc/BRIEF.md
# Programmed-I/O Disk Task-File Register Block

This block is the device side of a small disk controller that a host drives purely by programmed I/O. It decodes a window of eight byte-wide port offsets. These offsets hold a sector count, a 24-bit starting block number split across three byte registers, and a drive-select byte. A further offset is the command register when written and the status register when read. When the host issues a read command, the block raises busy for a programmable number of cycles. It then raises data-request, and the host pulls each 512-byte sector out of the data port as 256 sixteen-bit words.

Sector contents come from an internal block store. The store is computed from the block number and the byte offset, so no memory array is needed. If more than one sector was requested, the block returns to busy between sectors and advances to the next block number. It goes idle once the host has read the last word. A command that names another drive is dropped. An unknown opcode raises an error flag instead of starting work.

Top module: `pio_disk_regs`

## Requirements
- R1: Writes to offsets 2 (sector count), 3, 4 and 5 (block number bits 7:0, 15:8 and 23:16) and 6 (drive select) are held and read back on port_rdata[7:0] with upper bits zero. Offset 1 has no storage and reads 0.
- R2: Reading offset 7 returns status with bit 7 = busy, bit 3 = data-request, bit 0 = error and all other bits 0. Status reads change nothing, so back-to-back reads return the same value.
- R3: Writing 0x20 to offset 7 while drive-select bit 4 matches the implemented drive (default 0) shows busy in the cycle after the write. Busy stays set for exactly LATENCY cycles, then clears as data-request sets.
- R4: In data-request, each read of offset 0 returns the next word of the current block. Word w carries store byte 2w in bits 7:0 and byte 2w+1 in bits 15:8. Store byte k of block b is b[7:0]^b[15:8]^b[23:16]^k[7:0]^k[8]. The first block is the programmed block number.
- R5: After the 256th word of a sector that is not the last, busy returns for LATENCY cycles and the next block (number + 1) follows. After the 256th word of the last sector, status becomes 0x00.
- R6: Reads of offset 0 while data-request is clear return 0 and do not advance the word position. The word sequence also pauses across cycles with no data read.
- R7: A command written while drive-select bit 4 names the other drive is ignored, and status keeps its prior value.
- R8: Any opcode other than 0x20 sets the error bit without busy. A later accepted 0x20 command clears it.
- R9: Command writes made while busy or data-request is set are ignored.
- R10: After reset, all registers and the status read as 0, and offset 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_addr | input | 3 | Register offset within the window |
| port_wr | input | 1 | Write strobe for port_wdata at port_addr |
| port_rd | input | 1 | Read strobe; advances the word position on offset 0 |
| port_wdata | input | 8 | Write data byte |
| port_rdata | output | 16 | Read data for port_addr, combinational |

## Verification
The hardest state to reach is the sector boundary. Only after the host has drained all 256 words of a sector does the block fall back to busy and move to the next block number. The stimulus requests two sectors and pauses the host partway through the first sector. It then reads every word and probes the data port once inside the second busy window. A command is also written during transfer, to show it is ignored without disturbing the sequence.

// File: rtl/pio_disk_pkg.sv
package pio_disk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_XFER = 2'd2
    } seq_state_e;

    localparam logic [7:0] OP_READ_SECTORS = 8'h20;

    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_COUNT = 3'd2;
    localparam logic [2:0] OFS_BLK0  = 3'd3;
    localparam logic [2:0] OFS_BLK1  = 3'd4;
    localparam logic [2:0] OFS_BLK2  = 3'd5;
    localparam logic [2:0] OFS_DRIVE = 3'd6;
    localparam logic [2:0] OFS_CMDST = 3'd7;
endpackage

// File: rtl/pio_disk_taskfile.sv
module pio_disk_taskfile
    import pio_disk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  port_addr,
    input  logic        port_wr,
    input  logic [7:0]  port_wdata,
    output logic [7:0]  sec_count,
    output logic [23:0] blk_start,
    output logic [7:0]  drive_sel
);
    typedef struct packed {
        logic [7:0] count;
        logic [7:0] blk0;
        logic [7:0] blk1;
        logic [7:0] blk2;
        logic [7:0] drive;
    } tf_regs_t;

    tf_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (port_wr) begin
            case (port_addr)
                OFS_COUNT: r_d.count = port_wdata;
                OFS_BLK0:  r_d.blk0  = port_wdata;
                OFS_BLK1:  r_d.blk1  = port_wdata;
                OFS_BLK2:  r_d.blk2  = port_wdata;
                OFS_DRIVE: r_d.drive = port_wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sec_count = r_q.count;
    assign blk_start = {r_q.blk2, r_q.blk1, r_q.blk0};
    assign drive_sel = r_q.drive;
endmodule

// File: rtl/pio_disk_store.sv
module pio_disk_store #(
    parameter int BLK_W  = 24,
    parameter int WIDX_W = 8
) (
    input  logic [BLK_W-1:0]  blk,
    input  logic [WIDX_W-1:0] widx,
    output logic [15:0]       word
);
    localparam int LANES = (BLK_W + 7) / 8;

    logic [8*LANES-1:0] blk_ext;
    logic [7:0]         blk_fold;
    logic [WIDX_W:0]    k_lo, k_hi;

    assign blk_ext = (8*LANES)'(blk);

    always_comb begin
        blk_fold = '0;
        for (int i = 0; i < LANES; i++) blk_fold ^= blk_ext[8*i +: 8];
    end

    assign k_lo = {widx, 1'b0};
    assign k_hi = {widx, 1'b1};

    function automatic logic [7:0] store_byte(input logic [7:0] f, input logic [WIDX_W:0] k);
        logic [15:0] kx;
        kx = 16'(k);
        return f ^ kx[7:0] ^ {7'b0, kx[8]};
    endfunction

    assign word = {store_byte(blk_fold, k_hi), store_byte(blk_fold, k_lo)};
endmodule

// File: rtl/pio_disk_seq.sv
module pio_disk_seq
    import pio_disk_pkg::*;
#(
    parameter int LATENCY  = 4,
    parameter int WORDS    = 256,
    parameter int BLK_W    = 24,
    parameter bit DRIVE_ID = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_code,
    input  logic              cmd_drive,
    input  logic [7:0]        sec_count,
    input  logic [BLK_W-1:0]  blk_start,
    input  logic              data_rd,
    output logic              busy,
    output logic              drq,
    output logic              err,
    output logic [BLK_W-1:0]  cur_blk,
    output logic [$clog2(WORDS)-1:0] widx
);
    localparam int WIDX_W = $clog2(WORDS);
    localparam int TMR_W  = $clog2(LATENCY + 1);
    localparam int LEFT_W = 9;

    typedef struct packed {
        seq_state_e          state;
        logic [TMR_W-1:0]    timer;
        logic [LEFT_W-1:0]   left;
        logic [BLK_W-1:0]    blk;
        logic [WIDX_W-1:0]   widx;
        logic                err;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.state)
            ST_IDLE: begin
                if (cmd_wr && (cmd_drive == DRIVE_ID)) begin
                    if (cmd_code == OP_READ_SECTORS) begin
                        s_d.state = ST_BUSY;
                        s_d.timer = '0;
                        s_d.left  = (sec_count == 8'd0) ? LEFT_W'(256) : LEFT_W'(sec_count);
                        s_d.blk   = blk_start;
                        s_d.widx  = '0;
                        s_d.err   = 1'b0;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
            end
            ST_BUSY: begin
                if (s_q.timer == TMR_W'(LATENCY - 1)) begin
                    s_d.state = ST_XFER;
                    s_d.timer = '0;
                end else begin
                    s_d.timer = s_q.timer + TMR_W'(1);
                end
            end
            ST_XFER: begin
                if (data_rd) begin
                    if (s_q.widx == WIDX_W'(WORDS - 1)) begin
                        s_d.widx = '0;
                        s_d.left = s_q.left - LEFT_W'(1);
                        if (s_q.left == LEFT_W'(1)) begin
                            s_d.state = ST_IDLE;
                        end else begin
                            s_d.state = ST_BUSY;
                            s_d.timer = '0;
                            s_d.blk   = s_q.blk + BLK_W'(1);
                        end
                    end else begin
                        s_d.widx = s_q.widx + WIDX_W'(1);
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = (s_q.state == ST_BUSY);
    assign drq     = (s_q.state == ST_XFER);
    assign err     = s_q.err;
    assign cur_blk = s_q.blk;
    assign widx    = s_q.widx;

    // R2
    busy_drq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && drq));

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cmd_wr) || $past(drq)));

    // R6
    widx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_rd |=> $stable(widx));

    // R5
    drq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drq) |-> $past(data_rd));

    // R8
    err_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
endmodule

// File: rtl/pio_disk_regs.sv
module pio_disk_regs
    import pio_disk_pkg::*;
#(
    parameter int LATENCY  = 4,
    parameter int WORDS    = 256,
    parameter bit DRIVE_ID = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  port_addr,
    input  logic        port_wr,
    input  logic        port_rd,
    input  logic [7:0]  port_wdata,
    output logic [15:0] port_rdata
);
    localparam int BLK_W  = 24;
    localparam int WIDX_W = $clog2(WORDS);

    logic [7:0]        sec_count, drive_sel;
    logic [BLK_W-1:0]  blk_start, cur_blk;
    logic [WIDX_W-1:0] widx;
    logic              busy, drq, err;
    logic              cmd_wr, data_rd;
    logic [15:0]       store_word;
    logic [7:0]        status;

    assign cmd_wr  = port_wr && (port_addr == OFS_CMDST);
    assign data_rd = port_rd && (port_addr == OFS_DATA) && drq;

    pio_disk_taskfile u_tf (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_addr  (port_addr),
        .port_wr    (port_wr),
        .port_wdata (port_wdata),
        .sec_count  (sec_count),
        .blk_start  (blk_start),
        .drive_sel  (drive_sel)
    );

    pio_disk_seq #(
        .LATENCY  (LATENCY),
        .WORDS    (WORDS),
        .BLK_W    (BLK_W),
        .DRIVE_ID (DRIVE_ID)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_code  (port_wdata),
        .cmd_drive (drive_sel[4]),
        .sec_count (sec_count),
        .blk_start (blk_start),
        .data_rd   (data_rd),
        .busy      (busy),
        .drq       (drq),
        .err       (err),
        .cur_blk   (cur_blk),
        .widx      (widx)
    );

    pio_disk_store #(
        .BLK_W  (BLK_W),
        .WIDX_W (WIDX_W)
    ) u_store (
        .blk  (cur_blk),
        .widx (widx),
        .word (store_word)
    );

    assign status = {busy, 3'b000, drq, 2'b00, err};

    always_comb begin
        case (port_addr)
            OFS_DATA:  port_rdata = drq ? store_word : 16'h0000;
            OFS_COUNT: port_rdata = {8'h00, sec_count};
            OFS_BLK0:  port_rdata = {8'h00, blk_start[7:0]};
            OFS_BLK1:  port_rdata = {8'h00, blk_start[15:8]};
            OFS_BLK2:  port_rdata = {8'h00, blk_start[23:16]};
            OFS_DRIVE: port_rdata = {8'h00, drive_sel};
            OFS_CMDST: port_rdata = {8'h00, status};
            default:   port_rdata = 16'h0000;
        endcase
    end

    // R6
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_addr == OFS_DATA && !drq) |-> (port_rdata == 16'h0000));
endmodule

// File: tb/sim_pio_disk_regs.sv
module sim_pio_disk_regs;
    localparam int LATENCY = 4;
    localparam int WORDS   = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  port_addr = '0;
    logic        port_wr = 1'b0;
    logic        port_rd = 1'b0;
    logic [7:0]  port_wdata = '0;
    logic [15:0] port_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pio_disk_regs #(.LATENCY(LATENCY), .WORDS(WORDS), .DRIVE_ID(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .port_wr(port_wr),
        .port_rd(port_rd), .port_wdata(port_wdata), .port_rdata(port_rdata)
    );

    // {offset, write byte, expected readback}
    localparam logic [18:0] VEC [0:5] = '{
        {3'd2, 8'h02, 8'h02},
        {3'd3, 8'hA5, 8'hA5},
        {3'd4, 8'h3C, 8'h3C},
        {3'd5, 8'h81, 8'h81},
        {3'd6, 8'hE0, 8'hE0},
        {3'd1, 8'h77, 8'h00}
    };

    function automatic logic [15:0] exp_word(input logic [23:0] b, input int w);
        logic [7:0] f;
        logic [8:0] k0, k1;
        f  = b[7:0] ^ b[15:8] ^ b[23:16];
        k0 = 9'(2 * w);
        k1 = 9'(2 * w + 1);
        return {f ^ k1[7:0] ^ {7'b0, k1[8]}, f ^ k0[7:0] ^ {7'b0, k0[8]}};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        port_addr = a; port_wdata = d; port_wr = 1'b1;
        @(negedge clk); #1;
        port_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        port_addr = a; port_rd = 1'b1;
        #1 d = port_rdata;
        @(negedge clk); #1;
        port_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] d);
        port_addr = a;
        #1 d = port_rdata;
    endtask

    task automatic count_busy(output int n);
        logic [15:0] s;
        n = 0;
        peek(3'd7, s);
        while (s[7] && n < 100) begin
            n++;
            @(negedge clk); #1;
            peek(3'd7, s);
        end
    endtask

    task automatic read_sector(input logic [23:0] b, input string req);
        logic [15:0] v;
        int bad;
        bad = 0;
        for (int w = 0; w < WORDS; w++) begin
            rd(3'd0, v);
            if (v !== exp_word(b, w)) begin
                if (bad == 0) check(req, v, exp_word(b, w));
                bad++;
            end
        end
        if (bad == 0) check(req, 16'h0, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v2;
        int n;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        for (int a = 0; a < 8; a++) begin
            peek(3'(a), v);
            check("R10", v, 16'h0000);
        end

        // R1 register table
        foreach (VEC[i]) wr(VEC[i][18:16], VEC[i][15:8]);
        foreach (VEC[i]) begin
            rd(VEC[i][18:16], v);
            check("R1", v, {8'h00, VEC[i][7:0]});
        end

        // R8 unknown opcode sets error, no busy
        wr(3'd7, 8'h30);
        rd(3'd7, v);
        rd(3'd7, v2);
        check("R8", v, 16'h0001);
        check("R2", v2, v);
        repeat (LATENCY + 2) @(negedge clk);
        #1 peek(3'd7, v);
        check("R8", v, 16'h0001);

        // R7 other drive ignored
        wr(3'd6, 8'hF0);
        wr(3'd7, 8'h20);
        for (int i = 0; i < LATENCY + 2; i++) begin
            peek(3'd7, v);
            if (i == 0 || i == LATENCY + 1) check("R7", v, 16'h0001);
            @(negedge clk); #1;
        end

        // two-sector read from block 0x000105
        wr(3'd6, 8'hE0);
        wr(3'd2, 8'h02);
        wr(3'd3, 8'h05);
        wr(3'd4, 8'h01);
        wr(3'd5, 8'h00);
        rd(3'd0, v);
        check("R6", v, 16'h0000);
        wr(3'd7, 8'h20);
        peek(3'd7, v);
        check("R3", v, 16'h0080);
        count_busy(n);
        check("R3", 16'(n), 16'(LATENCY));
        peek(3'd7, v);
        check("R8", v, 16'h0008);

        // R9 command during transfer ignored
        wr(3'd7, 8'h30);
        peek(3'd7, v);
        check("R9", v, 16'h0008);

        // R4 first words, pause, continue
        rd(3'd0, v); check("R4", v, exp_word(24'h000105, 0));
        rd(3'd0, v); check("R4", v, exp_word(24'h000105, 1));
        repeat (3) @(negedge clk);
        #1 rd(3'd7, v); check("R6", v, 16'h0008);
        for (int w = 2; w < WORDS; w++) begin
            rd(3'd0, v);
            if (w == 2 || w == WORDS - 1) check("R4", v, exp_word(24'h000105, w));
        end

        // R5 busy between sectors, probe data during busy
        rd(3'd0, v);
        check("R6", v, 16'h0000);
        count_busy(n);
        check("R5", 16'(n), 16'(LATENCY - 1));
        read_sector(24'h000106, "R5");
        peek(3'd7, v);
        check("R5", v, 16'h0000);
        rd(3'd0, v);
        check("R6", v, 16'h0000);

        // R8 good command clears earlier error; R6 sequence starts at word 0
        wr(3'd7, 8'h31);
        wr(3'd2, 8'h01);
        wr(3'd7, 8'h20);
        count_busy(n);
        rd(3'd0, v);
        check("R6", v, exp_word(24'h000105, 0));
        peek(3'd7, v);
        check("R8", v, 16'h0008);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule